// File: doc/BRIEF.md
# Parallel Prefix Binary Adder

This block adds two unsigned or two's-complement operands of `WIDTH` bits together with a carry-in. It returns the `WIDTH`-bit sum and the carry-out. The work is split into three stages. The first stage forms a generate bit and a propagate bit for every position. The second is a tree of associative (generate, propagate) merge nodes that resolves every carry at once. The third forms each sum bit from its propagate bit and the carry coming up from the bit below.

The shape of the carry tree is a parameter. It can be a uniform-stride tree with one merge per position per level, a sparse tree with an up-sweep and a down-sweep, or a divide-and-conquer tree whose block tops fan out widely. A second parameter lets the tree use the OR of the operand bits instead of their XOR as its transfer term. All choices give bit-identical results. They differ only in node count, depth and fan-out. The carry-in enters as the transfer from an imaginary position below bit 0. An optional output register turns the block into a one-cycle stage.

Top module: `ppfx_adder`

## Requirements
- R1: `out_sum` equals the low `WIDTH` bits of `in_a + in_b + in_cin` for every input combination, with the default uniform-stride tree.
- R2: `out_cout` equals bit `WIDTH` of the full-width sum `in_a + in_b + in_cin`.
- R3: A carry-in crosses a full run of transfer positions. With `in_a` all ones, `in_b` zero and `in_cin` one, the sum is zero and the carry-out is one.
- R4: The up/down-sweep tree (`NET_KIND = NET_BK`) gives outputs bit-identical to R1 and R2 for every input.
- R5: The divide-and-conquer tree (`NET_KIND = NET_SK`) gives outputs bit-identical to R1 and R2 for every input.
- R6: When the tree uses the OR transfer term (`ALIVE_NET = 1`), the outputs stay bit-identical to R1 and R2.
- R7: A position where both operand bits are one always sends a carry to the next position. A position where both are zero never does, whatever lies below it.
- R8: With `OUT_REG = 1`, the outputs show the result of the operands sampled at the previous rising edge of `clk`. They hold between edges. While `rst_n` is low they read zero.
- R9: With `OUT_REG = 0`, the outputs follow the operands within the same clock period, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and for the checks |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| in_cin | input | 1 | Carry into bit 0 |
| out_sum | output | WIDTH | Sum bits |
| out_cout | output | 1 | Carry out of the top bit |

## Verification
The assertions sample the operands and outputs at the rising clock edge. They assume the operands are stable and fully known at that edge, and that reset starts low at time zero. The registered check also assumes one full cycle of known operands after reset before it compares anything. The bench drives every operand change on the falling edge. It reads the combinational outputs one nanosecond later and the registered ones just after the rising edge, so every assertion sees settled, defined values. The tree-internal checks on carry creation, absorption and pass-through hold for any defined operands. The random sweep therefore mixes long transfer runs, absorbing bits and carry-creating bits freely.

// File: rtl/ppfx_pkg.sv
package ppfx_pkg;

    typedef enum logic [1:0] {
        NET_KS = 2'd0,
        NET_BK = 2'd1,
        NET_SK = 2'd2
    } net_kind_e;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Merge an upper span (hi) with the span directly beneath it (lo).
    function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

endpackage

// File: rtl/ppfx_gp_stage.sv
module ppfx_gp_stage #(
    parameter int N         = 16,
    parameter bit ALIVE_NET = 1'b0
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         cin,
    output logic [N-1:0] gen,
    output logic [N-1:0] prp_net,
    output logic [N-1:0] prp_sum
);

    logic [N-1:0] raw_gen;
    logic [N-1:0] xor_prp;
    logic [N-1:0] or_prp;

    always_comb begin
        raw_gen = op_a & op_b;
        xor_prp = op_a ^ op_b;
        or_prp  = op_a | op_b;
    end

    if (ALIVE_NET) begin : g_alive
        assign prp_net = or_prp;
    end else begin : g_xor
        assign prp_net = xor_prp;
    end

    // carry-in behaves as the generate of a position under bit 0
    always_comb begin
        gen    = raw_gen;
        gen[0] = raw_gen[0] | (prp_net[0] & cin);
    end

    assign prp_sum = xor_prp;

endmodule

// File: rtl/ppfx_prefix_net.sv
module ppfx_prefix_net
    import ppfx_pkg::*;
#(
    parameter int        N    = 16,
    parameter net_kind_e KIND = NET_KS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] gen,
    input  logic [N-1:0] prp,
    output logic [N-1:0] carry
);

    localparam int LOG    = $clog2(N);
    localparam int LEVELS = 2 * LOG;

    gp_t lvl [0:LEVELS][0:N-1];

    for (genvar i = 0; i < N; i++) begin : g_in
        assign lvl[0][i] = '{g: gen[i], p: prp[i]};
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int D    = (l < LOG) ? (1 << l) : 1;
        localparam bit DOWN = (l >= LOG) && (l < LEVELS - 1);
        localparam int S    = DOWN ? (2 * LOG - 2 - l) : 0;
        for (genvar i = 0; i < N; i++) begin : g_bit
            if (KIND == NET_KS && l < LOG && i >= D) begin : g_ks
                assign lvl[l+1][i] = gp_merge(lvl[l][i], lvl[l][i-D]);
            end else if (KIND == NET_SK && l < LOG && ((i >> l) & 1) == 1) begin : g_sk
                assign lvl[l+1][i] = gp_merge(lvl[l][i], lvl[l][((i >> l) << l) - 1]);
            end else if (KIND == NET_BK && l < LOG && ((i + 1) % (2 * D)) == 0) begin : g_bk_up
                assign lvl[l+1][i] = gp_merge(lvl[l][i], lvl[l][i-D]);
            end else if (KIND == NET_BK && DOWN &&
                         ((i + 1) % (1 << (S + 1))) == (1 << S) && i > (1 << S)) begin : g_bk_dn
                assign lvl[l+1][i] = gp_merge(lvl[l][i], lvl[l][i-(1 << S)]);
            end else begin : g_buf
                assign lvl[l+1][i] = lvl[l][i];
            end
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_out
        assign carry[i] = lvl[LEVELS][i].g;
    end

    // R7
    gen_makes_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen & ~carry) == '0);
    // R7
    absorb_blocks_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (carry & ~(gen | prp)) == '0);
    // R3
    transfer_passes_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((prp[N-1:1] & ~gen[N-1:1]) & (carry[N-1:1] ^ carry[N-2:0])) == '0);
    // R3
    top_span_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl[LEVELS][N-1].p == (&prp));

endmodule

// File: rtl/ppfx_sum_stage.sv
module ppfx_sum_stage #(
    parameter int N = 16
) (
    input  logic [N-1:0] prp_sum,
    input  logic [N-1:0] carry,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout
);

    logic [N-1:0] carry_below;

    always_comb begin
        carry_below = {carry[N-2:0], cin};
        sum         = prp_sum ^ carry_below;
        cout        = carry[N-1];
    end

endmodule

// File: rtl/ppfx_adder.sv
module ppfx_adder
    import ppfx_pkg::*;
#(
    parameter int        WIDTH     = 16,
    parameter net_kind_e NET_KIND  = NET_KS,
    parameter bit        ALIVE_NET = 1'b0,
    parameter bit        OUT_REG   = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             in_cin,
    output logic [WIDTH-1:0] out_sum,
    output logic             out_cout
);

    localparam int RW = WIDTH + 1;

    typedef struct packed {
        logic             cout;
        logic [WIDTH-1:0] sum;
    } res_t;

    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] prp_net;
    logic [WIDTH-1:0] prp_sum;
    logic [WIDTH-1:0] carry;
    logic [WIDTH-1:0] sum_c;
    logic             cout_c;
    res_t             res_d;

    ppfx_gp_stage #(.N(WIDTH), .ALIVE_NET(ALIVE_NET)) u_gp (
        .op_a    (in_a),
        .op_b    (in_b),
        .cin     (in_cin),
        .gen     (gen),
        .prp_net (prp_net),
        .prp_sum (prp_sum)
    );

    ppfx_prefix_net #(.N(WIDTH), .KIND(NET_KIND)) u_net (
        .clk   (clk),
        .rst_n (rst_n),
        .gen   (gen),
        .prp   (prp_net),
        .carry (carry)
    );

    ppfx_sum_stage #(.N(WIDTH)) u_sum (
        .prp_sum (prp_sum),
        .carry   (carry),
        .cin     (in_cin),
        .sum     (sum_c),
        .cout    (cout_c)
    );

    always_comb begin
        res_d.cout = cout_c;
        res_d.sum  = sum_c;
    end

    if (OUT_REG) begin : g_reg
        res_t res_q;
        logic armed_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q   <= '0;
                armed_q <= 1'b0;
            end else begin
                res_q   <= res_d;
                armed_q <= 1'b1;
            end
        end

        assign out_sum  = res_q.sum;
        assign out_cout = res_q.cout;

        // R8
        reg_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
            armed_q |=> {out_cout, out_sum} ==
                $past(RW'({1'b0, in_a}) + RW'({1'b0, in_b}) + RW'(in_cin)));
        // R8
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |-> ({out_cout, out_sum} == '0));
    end else begin : g_comb
        assign out_sum  = res_d.sum;
        assign out_cout = res_d.cout;

        // R1 R2 R9
        comb_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
            {out_cout, out_sum} ==
                (RW'({1'b0, in_a}) + RW'({1'b0, in_b}) + RW'(in_cin)));
    end

endmodule

// File: tb/test_ppfx_adder.sv
module test_ppfx_adder;
    import ppfx_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a16 = '0;
    logic [15:0] b16 = '0;
    logic        c16 = 1'b0;
    logic [63:0] a64 = '0;
    logic [63:0] b64 = '0;
    logic        c64 = 1'b0;

    logic [15:0] s_ks, s_bk, s_sk, s_al;
    logic        co_ks, co_bk, co_sk, co_al;
    logic [63:0] s_rg;
    logic        co_rg;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ppfx_adder #(.WIDTH(16), .NET_KIND(NET_KS)) i_ppfx_adder (
        .clk(clk), .rst_n(rst_n), .in_a(a16), .in_b(b16), .in_cin(c16),
        .out_sum(s_ks), .out_cout(co_ks));
    ppfx_adder #(.WIDTH(16), .NET_KIND(NET_BK)) i_ppfx_adder_bk (
        .clk(clk), .rst_n(rst_n), .in_a(a16), .in_b(b16), .in_cin(c16),
        .out_sum(s_bk), .out_cout(co_bk));
    ppfx_adder #(.WIDTH(16), .NET_KIND(NET_SK)) i_ppfx_adder_sk (
        .clk(clk), .rst_n(rst_n), .in_a(a16), .in_b(b16), .in_cin(c16),
        .out_sum(s_sk), .out_cout(co_sk));
    ppfx_adder #(.WIDTH(16), .NET_KIND(NET_KS), .ALIVE_NET(1'b1)) i_ppfx_adder_al (
        .clk(clk), .rst_n(rst_n), .in_a(a16), .in_b(b16), .in_cin(c16),
        .out_sum(s_al), .out_cout(co_al));
    ppfx_adder #(.WIDTH(64), .NET_KIND(NET_SK), .OUT_REG(1'b1)) i_ppfx_adder_rg (
        .clk(clk), .rst_n(rst_n), .in_a(a64), .in_b(b64), .in_cin(c64),
        .out_sum(s_rg), .out_cout(co_rg));

    task automatic chk(input string req, input logic [64:0] got, input logic [64:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // drive 16-bit operands off the edge and compare every tree variant
    task automatic apply16(input logic [15:0] a, input logic [15:0] b, input logic c);
        logic [16:0] e;
        @(negedge clk);
        a16 = a; b16 = b; c16 = c;
        e = {1'b0, a} + {1'b0, b} + 17'(c);
        #1;
        chk("R1 sum", 65'(s_ks), 65'(e[15:0]));
        chk("R2 cout", 65'(co_ks), 65'(e[16]));
        chk("R4 bk", 65'({co_bk, s_bk}), 65'(e));
        chk("R5 sk", 65'({co_sk, s_sk}), 65'(e));
        chk("R6 alive", 65'({co_al, s_al}), 65'(e));
    endtask

    task automatic t_reset();
        #1;
        chk("R8 reset zero", 65'({co_rg, s_rg}), 65'd0);
        repeat (3) @(negedge clk);
        chk("R8 reset held zero", 65'({co_rg, s_rg}), 65'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_corners();
        apply16(16'h0000, 16'h0000, 1'b0);
        apply16(16'hFFFF, 16'hFFFF, 1'b1);
        apply16(16'h8000, 16'h8000, 1'b0);
        apply16(16'h7FFF, 16'h0001, 1'b0);
        // R3 full transfer run
        apply16(16'hFFFF, 16'h0000, 1'b1);
        chk("R3 ripple sum", 65'(s_ks), 65'd0);
        chk("R3 ripple cout", 65'(co_ks), 65'd1);
        apply16(16'h5555, 16'hAAAA, 1'b1);
        chk("R3 mixed run", 65'({co_sk, s_sk}), 65'h1_0000);
    endtask

    task automatic t_gen_kill();
        for (int i = 0; i < 15; i++) begin
            // R7 both ones at bit i, transfer run beneath carries cin nowhere
            apply16(16'(1 << i), 16'(1 << i), 1'b0);
            chk("R7 generate", 65'({co_bk, s_bk}), 65'(17'(1) << (i + 1)));
            // R7 both zero at bit i absorbs a carry from all ones below
            apply16(~(16'hFFFF << i) & 16'h7FFF, 16'h0000, 1'b1);
            chk("R7 absorb", 65'(s_ks[i]), 65'd1);
            chk("R7 absorb above", 65'({co_ks, s_ks} >> (i + 1)), 65'd0);
        end
    endtask

    task automatic t_sweep();
        logic [31:0] lf = 32'hACE1_1234;
        for (int n = 0; n < 300; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            apply16(lf[15:0], (n % 4 == 0) ? ~lf[15:0] : lf[31:16], lf[7]);
        end
    endtask

    task automatic t_comb_no_clock();
        @(posedge clk);
        #1;
        a16 = 16'h1234; b16 = 16'h4321; c16 = 1'b1;
        #1;
        // R9 output follows mid-cycle with no edge in between
        chk("R9 comb", 65'({co_ks, s_ks}), 65'h0_5556);
    endtask

    task automatic t_registered();
        logic [64:0] e;
        logic [64:0] prev;
        prev = 65'd0;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            a64 = {32'(n * 7919), 32'hFFFF_FFFF ^ 32'(n)};
            b64 = (n % 3 == 0) ? ~a64 : {32'(n), 32'(n * 104729)};
            c64 = n[0];
            e = {1'b0, a64} + {1'b0, b64} + 65'(c64);
            #1;
            // R8 holds last captured result until the edge
            if (n > 0) chk("R8 hold", {co_rg, s_rg}, prev);
            @(posedge clk);
            #1;
            chk("R8 registered", {co_rg, s_rg}, e);
            prev = e;
        end
    endtask

    initial begin
        t_reset();
        t_corners();
        t_gen_kill();
        t_sweep();
        t_comb_no_clock();
        t_registered();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule